// File: doc/BRIEF.md
# Change-of-State Input Interrupt Controller

This block watches a bank of digital inputs and raises a level interrupt request when a programmed change-of-state condition occurs. Every input is first brought into the clock domain through a two-flop synchroniser. The detector then works in one of two modes. In edge mode, any enabled channel that shows its selected edge is enough. In level mode, every enabled channel must sit at its selected level at the same moment.

Software reaches four word registers through a simple strobe interface. Two per-channel masks select the condition: one picks rising edges or high levels, the other picks falling edges or low levels. A control register picks the mode and holds the global enable. A status register returns the present synchronised input state, and reading it acknowledges the pending event. In level mode the detector fires once per match. It can fire again only after one of the selected inputs has changed level.

Top module: `cos_irq_ctrl`

## Requirements
- R1: Each input passes through two synchronising flops, and edges are found by comparing the synchronised value with its value one clock earlier. An enabled input change driven between clock edges raises `irq` at the third rising edge after the change, and not before.
- R2: In edge mode, a channel whose bit is set in the rise/high mask (word address 0) triggers on a 0-to-1 transition.
- R3: In edge mode, a channel whose bit is set in the fall/low mask (word address 1) triggers on a 1-to-0 transition. The opposite edge on that channel has no effect.
- R4: A channel whose bit is clear in both masks never causes an interrupt in either mode.
- R5: In level mode, an event fires only when every channel selected in either mask is at its selected level at the same time: high for a rise/high mask bit, low for a fall/low mask bit. A partial match does nothing.
- R6: In level mode, after an event fires, the detector stays quiet, even while the match persists and even if unselected inputs move, until a selected input changes level. Once that happens, a fresh match fires again.
- R7: A read of the status register (word address 3) returns the synchronised inputs in bits 15:0 with all upper bits zero, one edge after the read strobe. The same edge clears the pending event, so `irq` falls at that edge.
- R8: Control bit 2 is the global enable. While it is clear, `irq` stays low, but an event that occurs is still kept pending. `irq` rises at the same edge that writes the bit back to 1.
- R9: Control bit 0 selects edge mode and control bit 1 selects level mode. Level mode wins when both bits are set. With neither bit set, no condition is evaluated.
- R10: After reset, both masks and the control register read back as zero and `irq` is low. Writes to word addresses 0 to 2 read back unchanged. Writing zero to the control register and both masks stops all interrupt generation.
- R11: An event that is detected in the same cycle as a status read stays pending, and `irq` is high after that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | N_IN (16) | Asynchronous digital inputs |
| addr | input | 2 | Register word address |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Registered read data, valid the edge after `re` |
| irq | output | 1 | Registered interrupt request level |

## Verification
An input change shows up on `irq` at the third rising edge after it, so the bench drives inputs on falling edges. It confirms that `irq` is still low two falling edges later and high one falling edge after that. Read data is due at the edge that samples `re`. A monitor therefore pops the expected word from a scoreboard queue one time step after that edge. An acknowledge or an enable write changes `irq` at that same edge, and the bench samples it at the falling edge that follows. For the collision case, the status read is timed so that its edge is exactly the edge at which the detected event is latched.

// File: rtl/cos_pkg.sv
package cos_pkg;

  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned CTRL_W   = 3;
  localparam int unsigned EDGE_BIT = 0;
  localparam int unsigned LVL_BIT  = 1;
  localparam int unsigned EN_BIT   = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_HIMASK = 2'd0,
    REG_LOMASK = 2'd1,
    REG_CTRL   = 2'd2,
    REG_STAT   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_EDGE  = 2'd1,
    MODE_LEVEL = 2'd2
  } mode_e;

  function automatic mode_e decode_mode(input logic [CTRL_W-1:0] c);
    if (c[LVL_BIT])       return MODE_LEVEL;
    else if (c[EDGE_BIT]) return MODE_EDGE;
    else                  return MODE_OFF;
  endfunction

endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);

  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign cur  = stage_q[STAGES-1];
  assign prev = prev_q;

endmodule

// File: rtl/cos_detect.sv
module cos_detect
  import cos_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  mode_e        mode,
  input  logic [W-1:0] hi_mask,
  input  logic [W-1:0] lo_mask,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  output logic         fire
);

  logic [W-1:0] edge_hit;
  logic [W-1:0] lvl_ok;
  logic [W-1:0] moved;
  logic         armed_q;
  logic         any_sel;

  for (genvar i = 0; i < W; i++) begin : g_chan
    logic sel, rise, fall, meet;
    assign sel         = hi_mask[i] | lo_mask[i];
    assign rise        = cur[i] & ~prev[i];
    assign fall        = ~cur[i] & prev[i];
    assign meet        = (hi_mask[i] & cur[i]) | (lo_mask[i] & ~cur[i]);
    assign edge_hit[i] = (hi_mask[i] & rise) | (lo_mask[i] & fall);
    assign lvl_ok[i]   = meet | ~sel;
    assign moved[i]    = sel & (cur[i] ^ prev[i]);
  end

  assign any_sel = |(hi_mask | lo_mask);

  always_comb begin
    unique case (mode)
      MODE_EDGE:  fire = |edge_hit;
      MODE_LEVEL: fire = any_sel && (&lvl_ok) && armed_q;
      default:    fire = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                             armed_q <= 1'b1;
    else if (mode == MODE_LEVEL && fire) armed_q <= 1'b0;
    else if (|moved)                     armed_q <= 1'b1;
  end

endmodule

// File: rtl/cos_regs.sv
module cos_regs
  import cos_pkg::*;
#(
  parameter int W  = 16,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  input  logic [W-1:0]      cur,
  input  logic              fire,
  output logic [W-1:0]      hi_mask,
  output logic [W-1:0]      lo_mask,
  output logic [CTRL_W-1:0] ctrl,
  output logic              pending,
  output logic [DW-1:0]     rdata,
  output logic              irq
);

  localparam int PAD = DW - W;
  localparam int CPAD = DW - CTRL_W;

  reg_sel_e          sel;
  logic              stat_rd;
  logic              pend_nxt;
  logic [CTRL_W-1:0] ctrl_nxt;
  logic              unused_wbits;

  assign sel          = reg_sel_e'(addr);
  assign stat_rd      = re && (sel == REG_STAT);
  assign pend_nxt     = fire ? 1'b1 : (stat_rd ? 1'b0 : pending);
  assign ctrl_nxt     = (we && sel == REG_CTRL) ? wdata[CTRL_W-1:0] : ctrl;
  assign unused_wbits = ^wdata[DW-1:W];

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_mask <= '0;
      lo_mask <= '0;
      ctrl    <= '0;
      pending <= 1'b0;
      irq     <= 1'b0;
      rdata   <= '0;
    end else begin
      if (we && sel == REG_HIMASK) hi_mask <= wdata[W-1:0];
      if (we && sel == REG_LOMASK) lo_mask <= wdata[W-1:0];
      ctrl    <= ctrl_nxt;
      pending <= pend_nxt;
      irq     <= pend_nxt & ctrl_nxt[EN_BIT];
      if (re) begin
        unique case (sel)
          REG_HIMASK: rdata <= {{PAD{1'b0}}, hi_mask};
          REG_LOMASK: rdata <= {{PAD{1'b0}}, lo_mask};
          REG_CTRL:   rdata <= {{CPAD{1'b0}}, ctrl};
          default:    rdata <= {{PAD{1'b0}}, cur};
        endcase
      end
    end
  end

endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
  import cos_pkg::*;
#(
  parameter int N_IN        = 16,
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] din,
  input  logic [1:0]      addr,
  input  logic            we,
  input  logic            re,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            irq
);

  logic [N_IN-1:0]   cur_w;
  logic [N_IN-1:0]   prev_w;
  logic [N_IN-1:0]   hi_mask;
  logic [N_IN-1:0]   lo_mask;
  logic [CTRL_W-1:0] ctrl_q;
  logic              fire_w;
  logic              pending_w;
  mode_e             mode_w;

  assign mode_w = decode_mode(ctrl_q);

  cos_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .cur  (cur_w),
    .prev (prev_w)
  );

  cos_detect #(.W(N_IN)) u_detect (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_w),
    .hi_mask (hi_mask),
    .lo_mask (lo_mask),
    .cur     (cur_w),
    .prev    (prev_w),
    .fire    (fire_w)
  );

  cos_regs #(.W(N_IN), .DW(DW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .we      (we),
    .re      (re),
    .addr    (addr),
    .wdata   (wdata),
    .cur     (cur_w),
    .fire    (fire_w),
    .hi_mask (hi_mask),
    .lo_mask (lo_mask),
    .ctrl    (ctrl_q),
    .pending (pending_w),
    .rdata   (rdata),
    .irq     (irq)
  );

endmodule

// File: rtl/cos_irq_ctrl_chk.sv
module cos_irq_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic       re,
  input logic [1:0] addr,
  input logic       fire,
  input logic       pending,
  input logic [2:0] ctrl
);

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq |-> ctrl[2]); // R8

  AST_STAT_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (re && addr == 2'd3 && !fire) |=> !pending); // R7

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (rst)
    fire |=> pending); // R11

  AST_OFF_NO_FIRE: assert property (@(posedge clk) disable iff (rst)
    (ctrl[1:0] == 2'b00) |-> !fire); // R9

  AST_LEVEL_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    (fire && ctrl[1]) |=> !(fire && ctrl[1])); // R6

endmodule

bind cos_irq_ctrl cos_irq_ctrl_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq     (irq),
  .re      (re),
  .addr    (addr),
  .fire    (fire_w),
  .pending (pending_w),
  .ctrl    (ctrl_q)
);

// File: tb/test_cos_irq_ctrl.sv
module test_cos_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] din;
  logic [1:0]  addr;
  logic        we;
  logic        re;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  cos_irq_ctrl i_cos_irq_ctrl (
    .clk(clk), .rst(rst), .din(din), .addr(addr), .we(we), .re(re),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick(1);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    re = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    tick(1);
    re = 1'b0;
  endtask

  task automatic expect_fire(input string req);
    tick(2);
    chk({req, " irq before third edge"}, {31'd0, irq}, 32'd0);
    tick(1);
    chk({req, " irq at third edge"}, {31'd0, irq}, 32'd1);
  endtask

  task automatic expect_quiet(input string req);
    tick(4);
    chk({req, " irq stays low"}, {31'd0, irq}, 32'd0);
  endtask

  // monitor: scoreboard for read data
  always begin
    @(posedge clk);
    if (re) begin
      #1;
      if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; din = '0; addr = '0; we = 1'b0; re = 1'b0; wdata = '0;
    tick(5);
    rst = 1'b0;
    tick(1);
    // R10 reset state
    chk("R10 irq after reset", {31'd0, irq}, 32'd0);
    rd(2'd0, 32'd0, "R10 rise mask reset");
    rd(2'd1, 32'd0, "R10 fall mask reset");
    rd(2'd2, 32'd0, "R10 ctrl reset");

    // R1 R2 edge mode rising
    wr(2'd0, 32'h1); wr(2'd1, 32'h0); wr(2'd2, 32'h5);
    tick(3);
    chk("R2 idle", {31'd0, irq}, 32'd0);
    din[0] = 1'b1;
    expect_fire("R1 R2 rising ch0");
    rd(2'd3, 32'h1, "R7 status value");
    chk("R7 irq cleared by read", {31'd0, irq}, 32'd0);

    // R3 falling
    wr(2'd1, 32'h2);
    din[1] = 1'b1;
    expect_quiet("R3 rise on fall-only channel");
    din[1] = 1'b0;
    expect_fire("R3 falling ch1");
    rd(2'd3, 32'h1, "R7 status after fall");
    chk("R7 irq cleared", {31'd0, irq}, 32'd0);

    // R4 unselected channel
    din[5] = 1'b1;
    expect_quiet("R4 unselected rise");
    din[5] = 1'b0;
    expect_quiet("R4 unselected fall");

    // R8 enable masks irq but keeps event
    wr(2'd2, 32'h1);
    din[0] = 1'b0;
    tick(4);
    din[0] = 1'b1;
    tick(4);
    chk("R8 irq masked while disabled", {31'd0, irq}, 32'd0);
    wr(2'd2, 32'h5);
    chk("R8 irq back on enable", {31'd0, irq}, 32'd1);
    rd(2'd3, 32'h1, "R7 status after enable");
    chk("R7 irq cleared", {31'd0, irq}, 32'd0);

    // R11 event collides with status read
    wr(2'd1, 32'h3);
    din[0] = 1'b0;
    tick(2);
    rd(2'd3, 32'h0, "R11 status in collision");
    chk("R11 event kept across read", {31'd0, irq}, 32'd1);
    rd(2'd3, 32'h0, "R7 second status");
    chk("R11 cleared by second read", {31'd0, irq}, 32'd0);

    // R9 no mode
    wr(2'd2, 32'h4);
    din[0] = 1'b1;
    expect_quiet("R9 no mode rise");
    din[0] = 1'b0;
    expect_quiet("R9 no mode fall");

    // R5 level mode
    wr(2'd0, 32'h3); wr(2'd1, 32'h4); wr(2'd2, 32'h6);
    expect_quiet("R5 no match");
    din[0] = 1'b1;
    expect_quiet("R5 partial match");
    din[1] = 1'b1;
    expect_fire("R5 full match");
    rd(2'd3, 32'h3, "R7 status level");
    chk("R7 irq cleared", {31'd0, irq}, 32'd0);

    // R6 re-arm rule
    tick(5);
    chk("R6 held match no refire", {31'd0, irq}, 32'd0);
    din[5] = 1'b1;
    expect_quiet("R6 unselected move");
    din[5] = 1'b0;
    expect_quiet("R6 unselected move back");
    din[1] = 1'b0;
    expect_quiet("R6 selected change breaks match");
    din[1] = 1'b1;
    expect_fire("R6 refire after change");
    rd(2'd3, 32'h3, "R7 status refire");
    chk("R7 irq cleared", {31'd0, irq}, 32'd0);

    // R9 level wins over edge
    wr(2'd2, 32'h7);
    rd(2'd2, 32'h7, "R10 ctrl readback");
    din[1] = 1'b0;
    expect_quiet("R9 both bits ch1 low");
    din[0] = 1'b0;
    expect_quiet("R9 both bits ch0 low");
    din[0] = 1'b1;
    expect_quiet("R9 level wins over edge");
    rd(2'd0, 32'h3, "R10 rise mask readback");
    rd(2'd1, 32'h4, "R10 fall mask readback");

    // R10 zero disables
    wr(2'd2, 32'h0); wr(2'd0, 32'h0); wr(2'd1, 32'h0);
    din[1] = 1'b1;
    expect_quiet("R10 zeroed config");
    wr(2'd2, 32'h5);
    chk("R10 zero masks no pending", {31'd0, irq}, 32'd0);
    din[0] = 1'b0;
    expect_quiet("R10 zero masks edge mode");

    tick(3);
    chk("R7 all reads answered", exp_q.size(), 32'd0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule